// File: doc/BRIEF.md
# Cascaded Delta-Sigma Fraction Modulator

This block turns an integer part and an 8-bit fractional part into a stream of integer values whose long-run average equals the integer plus the fraction over 256. Each stage is an accumulator. The carry out of the adder is the one-bit quantized output, and the wrapped sum is the error that stays in the register. Overflow does the wraparound, so no explicit feedback subtraction is needed.

A second stage accumulates the first stage's residue. Its carry is differenced against its value from the previous step and added to the first-stage carry, which is delayed by one step so that both terms line up. This gives second-order noise shaping of the error. A select input picks first-order or second-order operation. The result suits either a divider modulus sequence or an oscillator dither word.

New values are produced only on an enable strobe, meant to coincide with the divider reload window. Between strobes the output holds.

Top module: `dsm_mash_top`

## Requirements
- R1: While rstN is low, and in the first cycle after its release, modOut reads 0 and both accumulators are empty.
- R2: modOut changes only on the clock edge at which stepEn is high, and becomes visible in the following cycle. Without stepEn, the output and all state hold.
- R3: With orderSel=0, each step adds fracIn to the 8-bit first accumulator. modOut becomes intIn plus that addition's carry (0 or 1).
- R4: With orderSel=1, the second accumulator adds the first accumulator's value from before the step. modOut becomes intIn plus the first-stage carry of the previous step, plus the current second-stage carry, minus the second-stage carry of the previous step.
- R5: modOut is a two's-complement signed value of INT_W+2 bits. With orderSel=1, the offset from intIn lies in -1..+2, so intIn=0 can give -1.
- R6: A step with fracIn=0 empties both accumulators and the stored carries, and gives modOut equal to intIn exactly.
- R7: While orderSel=0, steps keep the second accumulator and its stored carry at zero. A later switch to orderSel=1 starts stage two from an empty state.
- R8: Starting from empty state, 256 first-order steps sum to exactly fracIn above 256·intIn. 1024 second-order steps sum to within ±1 of 4·fracIn above 1024·intIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Update strobe (divider reload window) |
| orderSel | input | 1 | 0: first order, 1: second order |
| intIn | input | INT_W | Integer part N |
| fracIn | input | FRAC_W | Fractional part, in units of 1/2^FRAC_W |
| modOut | output | INT_W+2 | Signed modulated integer |

## Verification
On every cycle, the assertions check the following. The output holds without a strobe. A zero-fraction step yields intIn exactly. The offset stays within 0..1 in first order and within -1..+2 in second order. The control never raises update and flush together. Only the bench scenarios can show the exact carry sequence, and the latency alignment between the delayed first-stage carry and the differenced second-stage carry. The same holds for the clean start of stage two after an order switch, and for the long-run sums equalling the fraction.

// File: rtl/dsm_mash_pkg.sv
package dsm_mash_pkg;
  typedef struct packed {
    logic advance;
    logic flush;
    logic useSecond;
  } dsmStrobe_t;
endpackage

// File: rtl/dsm_acc.sv
module dsm_acc #(
  parameter int W = 8
) (
  input  logic [W-1:0] stateIn,
  input  logic [W-1:0] addend,
  output logic [W-1:0] residue,
  output logic         carry
);
  logic [W:0] total;
  always_comb begin
    total   = {1'b0, stateIn} + {1'b0, addend};
    residue = total[W-1:0];
    carry   = total[W];
  end
endmodule

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_mash_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              orderSel,
  input  logic [FRAC_W-1:0] fracIn,
  output dsmStrobe_t        stb
);
  logic fracZero;
  always_comb begin
    fracZero      = (fracIn == '0);
    stb.advance   = stepEn && !fracZero;
    stb.flush     = stepEn && fracZero;
    stb.useSecond = orderSel;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.advance, stb.flush}));
  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance || stb.flush) |-> stepEn);
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_mash_pkg::*;
#(
  parameter int FRAC_W     = 8,
  parameter int INT_W      = 8,
  parameter bit HAS_SECOND = 1'b1,
  localparam int OUT_W     = INT_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dsmStrobe_t              stb,
  input  logic [INT_W-1:0]        intIn,
  input  logic [FRAC_W-1:0]       fracIn,
  output logic signed [OUT_W-1:0] modOut
);
  logic [FRAC_W-1:0] err1, err2;
  logic [FRAC_W-1:0] nextErr1, nextErr2;
  logic              carry1, carry2;
  logic              carry1Dly, carry2Prev;
  logic              secondOn;
  logic signed [OUT_W-1:0] baseVal, firstVal, secondVal;

  dsm_acc #(.W(FRAC_W)) stage1_i (
    .stateIn(err1), .addend(fracIn), .residue(nextErr1), .carry(carry1));

  generate
    if (HAS_SECOND) begin : g_second
      dsm_acc #(.W(FRAC_W)) stage2_i (
        .stateIn(err2), .addend(err1), .residue(nextErr2), .carry(carry2));
      assign secondOn = stb.useSecond;
    end else begin : g_first_only
      assign nextErr2 = '0;
      assign carry2   = 1'b0;
      assign secondOn = 1'b0;
    end
  endgenerate

  always_comb begin
    baseVal   = $signed({2'b00, intIn});
    firstVal  = baseVal + $signed({{(OUT_W-1){1'b0}}, carry1});
    secondVal = baseVal + $signed({{(OUT_W-1){1'b0}}, carry1Dly})
              + $signed({{(OUT_W-1){1'b0}}, carry2})
              - $signed({{(OUT_W-1){1'b0}}, carry2Prev});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      err1       <= '0;
      err2       <= '0;
      carry1Dly  <= 1'b0;
      carry2Prev <= 1'b0;
      modOut     <= '0;
    end else if (stb.flush) begin
      err1       <= '0;
      err2       <= '0;
      carry1Dly  <= 1'b0;
      carry2Prev <= 1'b0;
      modOut     <= baseVal;
    end else if (stb.advance) begin
      err1      <= nextErr1;
      carry1Dly <= carry1;
      if (secondOn) begin
        err2       <= nextErr2;
        carry2Prev <= carry2;
        modOut     <= secondVal;
      end else begin
        err2       <= '0;
        carry2Prev <= 1'b0;
        modOut     <= firstVal;
      end
    end
  end

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.advance || stb.flush) |=> $stable(modOut));
  // R6
  zero_frac_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (modOut == $signed({2'b00, $past(intIn)})));
  // R3
  first_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !secondOn) |=>
      ((modOut - $signed({2'b00, $past(intIn)})) >= 0 &&
       (modOut - $signed({2'b00, $past(intIn)})) <= 1));
  // R5
  second_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && secondOn) |=>
      ((modOut - $signed({2'b00, $past(intIn)})) >= -1 &&
       (modOut - $signed({2'b00, $past(intIn)})) <= 2));
  // R7
  stage2_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !secondOn) |=> (err2 == '0 && !carry2Prev));
endmodule

// File: rtl/dsm_mash_top.sv
module dsm_mash_top #(
  parameter int FRAC_W     = 8,
  parameter int INT_W      = 8,
  parameter bit HAS_SECOND = 1'b1,
  localparam int OUT_W     = INT_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stepEn,
  input  logic                    orderSel,
  input  logic [INT_W-1:0]        intIn,
  input  logic [FRAC_W-1:0]       fracIn,
  output logic signed [OUT_W-1:0] modOut
);
  dsm_mash_pkg::dsmStrobe_t stb;

  dsm_ctrl #(.FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .orderSel(orderSel),
    .fracIn(fracIn), .stb(stb));

  dsm_datapath #(.FRAC_W(FRAC_W), .INT_W(INT_W), .HAS_SECOND(HAS_SECOND)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .intIn(intIn), .fracIn(fracIn),
    .modOut(modOut));
endmodule

// File: tb/dsm_mash_top_tb_top.sv
module dsm_mash_top_tb_top;
  localparam int FW = 8;
  localparam int IW = 8;
  localparam int OW = IW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0;
  logic orderSel = 1'b0;
  logic [IW-1:0] intIn = '0;
  logic [FW-1:0] fracIn = '0;
  logic signed [OW-1:0] modOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  int mE1 = 0, mE2 = 0, mC1d = 0, mC2p = 0, mOut = 0;

  always #5 clk = ~clk;

  dsm_mash_top dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .orderSel(orderSel),
    .intIn(intIn), .fracIn(fracIn), .modOut(modOut));

  function automatic int modelStep(int n, int f, bit ord);
    int s1, c1, s2, c2, y;
    if (f == 0) begin
      mE1 = 0; mE2 = 0; mC1d = 0; mC2p = 0;
      return n;
    end
    s1 = mE1 + f; c1 = s1 / 256;
    if (ord) begin
      s2 = mE2 + mE1; c2 = s2 / 256;
      y = n + mC1d + c2 - mC2p;
      mE2 = s2 % 256; mC2p = c2;
    end else begin
      y = n + c1;
      mE2 = 0; mC2p = 0;
    end
    mE1 = s1 % 256; mC1d = c1;
    return y;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at the negedge, check the result at the next negedge
  task automatic cycle(bit en, bit ord, int n, int f, string req);
    stepEn = en; orderSel = ord; intIn = IW'(n); fracIn = FW'(f);
    if (en) mOut = modelStep(n, f, ord);
    @(negedge clk);
    check(req, int'(modOut), mOut);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int sum;
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1", int'(modOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(modOut), 0);

    // R6 zero fraction gives N exactly, in both orders
    cycle(1, 1, 77, 0, "R6");
    cycle(1, 0, 200, 0, "R6");
    // R2 hold without strobe, even with inputs moving
    cycle(0, 1, 9, 55, "R2");
    cycle(0, 0, 3, 200, "R2");

    // R3 half fraction alternates, and a 256-step sum equals F
    cycle(1, 0, 10, 0, "R6");
    sum = 0;
    for (int k = 0; k < 256; k++) begin
      cycle(1, 0, 10, 128, "R3");
      sum += int'(modOut) - 10;
    end
    check("R8 first-order sum", sum, 128);
    cycle(1, 0, 10, 0, "R6");
    sum = 0;
    for (int k = 0; k < 256; k++) begin
      cycle(1, 0, 10, 37, "R3");
      sum += int'(modOut) - 10;
    end
    check("R8 first-order sum", sum, 37);

    // R7: first-order steps, then switch: stage two from empty
    for (int k = 0; k < 20; k++) cycle(1, 0, 4, 201, "R7");
    for (int k = 0; k < 20; k++) cycle(1, 1, 4, 201, "R7");

    // R4/R8 second order long-run sum
    cycle(1, 1, 50, 0, "R6");
    sum = 0;
    for (int k = 0; k < 1024; k++) begin
      cycle(1, 1, 50, 93, "R4");
      sum += int'(modOut) - 50;
    end
    checks++;
    if (sum < 4*93 - 1 || sum > 4*93 + 1) begin
      errors++;
      $display("FAIL R8 second-order sum actual %0d expected %0d+-1", sum, 4*93);
    end

    // R5 negative output with N=0 and the extremes of the fraction
    cycle(1, 1, 0, 0, "R6");
    for (int k = 0; k < 300; k++) cycle(1, 1, 0, 255, "R5");
    for (int k = 0; k < 300; k++) cycle(1, 1, 255, 1, "R5");

    // constrained random mix
    for (int k = 0; k < 5000; k++) begin
      bit en, ord;
      int f;
      en  = ($urandom_range(0, 3) != 0);
      ord = ($urandom_range(0, 4) != 0);
      f   = ($urandom_range(0, 15) == 0) ? 0 : $urandom_range(1, 255);
      cycle(en, ord, $urandom_range(0, 255), f, ord ? "R4" : "R3");
    end

    // R1 reset mid-run clears state
    cycle(1, 1, 20, 77, "R4");
    rstN = 1'b0; stepEn = 1'b0;
    #1;
    check("R1", int'(modOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    mE1 = 0; mE2 = 0; mC1d = 0; mC2p = 0; mOut = 0;
    @(negedge clk);
    check("R1", int'(modOut), 0);
    cycle(1, 1, 20, 200, "R1");
    cycle(1, 1, 20, 200, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule